// File: doc/BRIEF.md
# Periodic Clock-Calendar Register Unit

This block is a small real-time clock that is read through an index-and-data register pair. Software writes a register number to the index port and then reads the data port. The data port returns the selected time field or status byte. The block keeps seconds, minutes, hours, weekday, day of month, month and a one-byte year. All of them are binary counts, and the power-up time comes from parameters.

A prescaler runs on an input tick enable. It produces a periodic interrupt pulse at 1024 pulses per second, and it also produces the strobe that advances the calendar by one second. During the last few periodic intervals before each advance, an update-in-progress flag is raised. That flag shows up in the top bit of the first status byte. The other two status bytes read back fixed values. Writes to the data port, the fourth status register and any unknown index are not supported, and each of them raises a one-cycle error flag.

Top module: `clock_calendar_unit`

## Requirements
- R1: `pie_o` is a one-cycle pulse that fires once every `PI_DIV` input ticks and runs continuously from reset. `PI_PER_SEC` (1024) of these pulses make one second.
- R2: When `idx_wr` is high on a clock edge, `idx_in` is stored as the register index. Every later `data_rd` uses that index until the next index write.
- R3: Index 0x0A reads as 0x26 ORed with the update flag in bit 7. The update flag is high while the periodic count within the second is at least `PI_PER_SEC - UIP_LEAD`.
- R4: Index 0x0B reads as the constant 0x46 (binary data, 24-hour format).
- R5: Index 0x0C reads as 0x00.
- R6: A read of index 0x0D, or of any index outside {0x00,0x02,0x04,0x06,0x07,0x08,0x09,0x0A,0x0B,0x0C}, sets `err_o` for one cycle and leaves `rd_data` unchanged.
- R7: A data-port write (`data_wr`) sets `err_o` for one cycle and changes no time field.
- R8: The time fields are binary at these indices: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06 (0 to 6), day of month 0x07. Month at 0x08 reads as 1 to 12, and year at 0x09 reads as the calendar year minus `YEAR_BASE`.
- R9: The calendar advances one second on the clock edge after the final periodic pulse of a second. Seconds and minutes wrap at 60, hours at 24 and weekday at 7, each carrying into the next field.
- R10: The day of month wraps after the month's length (30 for months 4, 6, 9 and 11, 31 for the others, and 28 for February or 29 when `YEAR_BASE + year` is divisible by 4). Month 12 wraps to 1 and increments the year.
- R11: After reset, `rd_data`, `err_o` and `pie_o` are 0, the index is 0 and the time fields hold the `INIT_*` parameters.
- R12: `rd_data` and `err_o` are registered, so the value for a `data_rd` appears after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler input tick enable |
| idx_wr | input | 1 | Index port write strobe |
| idx_in | input | 8 | Register index to store |
| data_rd | input | 1 | Data port read strobe |
| data_wr | input | 1 | Data port write strobe (unsupported) |
| rd_data | output | 8 | Registered read data |
| err_o | output | 1 | One-cycle error flag |
| pie_o | output | 1 | Periodic interrupt pulse |

## Verification
A read returns its data and error flag on the edge that samples `data_rd`. The bench raises the strobe half a cycle before that edge and samples half a cycle after it. The periodic pulse rises on the edge that ends every `PI_DIV`-th tick. The seconds advance comes one edge after the final pulse of the second. To control this timing exactly, the bench drives the tick enable for an exact number of edges and then holds it low, which freezes the prescaler. It then idles one edge so that the pending advance can land before it reads any field. The update flag is checked one tick before and one tick after its threshold.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] IX_SEC  = 8'h00;
  localparam logic [7:0] IX_MIN  = 8'h02;
  localparam logic [7:0] IX_HR   = 8'h04;
  localparam logic [7:0] IX_WDAY = 8'h06;
  localparam logic [7:0] IX_MDAY = 8'h07;
  localparam logic [7:0] IX_MON  = 8'h08;
  localparam logic [7:0] IX_YR   = 8'h09;
  localparam logic [7:0] IX_STA  = 8'h0A;
  localparam logic [7:0] IX_STB  = 8'h0B;
  localparam logic [7:0] IX_STC  = 8'h0C;

  localparam logic [7:0] STA_FIXED = 8'h26;
  localparam logic [7:0] STB_FIXED = 8'h46;

  typedef struct packed {
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hr;
    logic [BYTE_W-1:0] wday;
    logic [BYTE_W-1:0] mday;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] yr;
  } ccu_time_t;

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    case (mon)
      8'd2:                    month_len = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: month_len = 8'd30;
      default:                 month_len = 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/ccu_prescaler.sv
module ccu_prescaler #(
  parameter int PI_DIV     = 32,
  parameter int PI_PER_SEC = 1024,
  parameter int UIP_LEAD   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic pie_o,
  output logic sec_stb_o,
  output logic uip_o
);
  localparam int PW = (PI_PER_SEC > 1) ? $clog2(PI_PER_SEC) : 1;
  localparam logic [PW-1:0] PI_LAST = PW'(PI_PER_SEC - 1);
  localparam logic [PW-1:0] UIP_AT  = PW'(PI_PER_SEC - UIP_LEAD);

  logic          wrap;
  logic [PW-1:0] pi_q;

  generate
    if (PI_DIV == 1) begin : g_nodiv
      assign wrap = tick;
    end else begin : g_div
      localparam int DW = $clog2(PI_DIV);
      localparam logic [DW-1:0] DIV_LAST = DW'(PI_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst)                           div_q <= '0;
        else if (tick && div_q == DIV_LAST) div_q <= '0;
        else if (tick)                     div_q <= div_q + 1'b1;
      end
      assign wrap = tick && (div_q == DIV_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pi_q      <= '0;
      pie_o     <= 1'b0;
      sec_stb_o <= 1'b0;
    end else begin
      pie_o     <= wrap;
      sec_stb_o <= wrap && (pi_q == PI_LAST);
      if (wrap) pi_q <= (pi_q == PI_LAST) ? '0 : pi_q + 1'b1;
    end
  end

  assign uip_o = (pi_q >= UIP_AT);
endmodule

// File: rtl/ccu_timekeep.sv
module ccu_timekeep
  import ccu_pkg::*;
#(
  parameter int YEAR_BASE = 1952,
  parameter ccu_time_t INIT_T = '0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      adv,
  output ccu_time_t tm_o
);
  ccu_time_t   t_q;
  logic [15:0] full_yr;
  logic        leap;
  logic [7:0]  mlen;

  assign full_yr = 16'(YEAR_BASE) + {8'h00, t_q.yr};
  assign leap    = (full_yr[1:0] == 2'b00);
  assign mlen    = month_len(t_q.mon, leap);

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q <= INIT_T;
    end else if (adv) begin
      if (t_q.sec != 8'd59) begin
        t_q.sec <= t_q.sec + 8'd1;
      end else begin
        t_q.sec <= 8'd0;
        if (t_q.min != 8'd59) begin
          t_q.min <= t_q.min + 8'd1;
        end else begin
          t_q.min <= 8'd0;
          if (t_q.hr != 8'd23) begin
            t_q.hr <= t_q.hr + 8'd1;
          end else begin
            t_q.hr   <= 8'd0;
            t_q.wday <= (t_q.wday == 8'd6) ? 8'd0 : t_q.wday + 8'd1;
            if (t_q.mday != mlen) begin
              t_q.mday <= t_q.mday + 8'd1;
            end else begin
              t_q.mday <= 8'd1;
              if (t_q.mon != 8'd12) begin
                t_q.mon <= t_q.mon + 8'd1;
              end else begin
                t_q.mon <= 8'd1;
                t_q.yr  <= t_q.yr + 8'd1;
              end
            end
          end
        end
      end
    end
  end

  assign tm_o = t_q;
endmodule

// File: rtl/ccu_regread.sv
module ccu_regread
  import ccu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ccu_time_t  tm,
  input  logic       uip,
  input  logic       idx_wr,
  input  logic [7:0] idx_in,
  input  logic       data_rd,
  input  logic       data_wr,
  output logic [7:0] rd_data,
  output logic       err_o,
  output logic [7:0] idx_o
);
  logic [7:0] idx_q;
  logic [7:0] sel_val;
  logic       sel_ok;

  always_comb begin
    sel_ok  = 1'b1;
    sel_val = 8'h00;
    case (idx_q)
      IX_SEC:  sel_val = tm.sec;
      IX_MIN:  sel_val = tm.min;
      IX_HR:   sel_val = tm.hr;
      IX_WDAY: sel_val = tm.wday;
      IX_MDAY: sel_val = tm.mday;
      IX_MON:  sel_val = tm.mon;
      IX_YR:   sel_val = tm.yr;
      IX_STA:  sel_val = {uip, 7'b0} | STA_FIXED;
      IX_STB:  sel_val = STB_FIXED;
      IX_STC:  sel_val = 8'h00;
      default: sel_ok  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= 8'h00;
      rd_data <= 8'h00;
      err_o   <= 1'b0;
    end else begin
      if (idx_wr) idx_q <= idx_in;
      if (data_rd && sel_ok) rd_data <= sel_val;
      err_o <= (data_rd && !sel_ok) || data_wr;
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/clock_calendar_unit.sv
module clock_calendar_unit
  import ccu_pkg::*;
#(
  parameter int PI_DIV     = 32,
  parameter int PI_PER_SEC = 1024,
  parameter int UIP_LEAD   = 8,
  parameter int YEAR_BASE  = 1952,
  parameter int INIT_SEC   = 0,
  parameter int INIT_MIN   = 0,
  parameter int INIT_HR    = 0,
  parameter int INIT_WDAY  = 0,
  parameter int INIT_MDAY  = 1,
  parameter int INIT_MON   = 1,
  parameter int INIT_YR    = 54
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       idx_wr,
  input  logic [7:0] idx_in,
  input  logic       data_rd,
  input  logic       data_wr,
  output logic [7:0] rd_data,
  output logic       err_o,
  output logic       pie_o
);
  localparam ccu_time_t INIT_T = '{
    sec: 8'(INIT_SEC), min: 8'(INIT_MIN), hr: 8'(INIT_HR), wday: 8'(INIT_WDAY),
    mday: 8'(INIT_MDAY), mon: 8'(INIT_MON), yr: 8'(INIT_YR)};

  logic      sec_stb;
  logic      uip;
  ccu_time_t tm_q;
  logic [7:0] idx_q;

  ccu_prescaler #(.PI_DIV(PI_DIV), .PI_PER_SEC(PI_PER_SEC), .UIP_LEAD(UIP_LEAD)) u_pre (
    .clk(clk), .rst(rst), .tick(tick),
    .pie_o(pie_o), .sec_stb_o(sec_stb), .uip_o(uip));

  ccu_timekeep #(.YEAR_BASE(YEAR_BASE), .INIT_T(INIT_T)) u_time (
    .clk(clk), .rst(rst), .adv(sec_stb), .tm_o(tm_q));

  ccu_regread u_rd (
    .clk(clk), .rst(rst), .tm(tm_q), .uip(uip),
    .idx_wr(idx_wr), .idx_in(idx_in), .data_rd(data_rd), .data_wr(data_wr),
    .rd_data(rd_data), .err_o(err_o), .idx_o(idx_q));
endmodule

// File: rtl/ccu_chk.sv
module ccu_chk
  import ccu_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       pie,
  input logic       sec_stb,
  input ccu_time_t  tm,
  input logic       data_rd,
  input logic       data_wr,
  input logic [7:0] idx,
  input logic [7:0] rd_data,
  input logic       err
);
  // R9
  clock_range_chk: assert property (@(posedge clk) disable iff (rst)
    tm.sec < 8'd60 && tm.min < 8'd60 && tm.hr < 8'd24 && tm.wday < 8'd7);

  // R10
  calendar_range_chk: assert property (@(posedge clk) disable iff (rst)
    tm.mon >= 8'd1 && tm.mon <= 8'd12 && tm.mday >= 8'd1 && tm.mday <= 8'd31);

  // R9
  sec_moves_on_stb_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tm.sec) |-> $past(sec_stb));

  // R1
  stb_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sec_stb |-> pie);

  // R7
  write_error_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> err);

  // R4
  status_b_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && idx == 8'h0B) |=> rd_data == 8'h46);

  // R6
  reg_d_error_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && idx == 8'h0D) |=> err);
endmodule

bind clock_calendar_unit ccu_chk u_chk (
  .clk(clk), .rst(rst), .pie(pie_o), .sec_stb(sec_stb), .tm(tm_q),
  .data_rd(data_rd), .data_wr(data_wr), .idx(idx_q), .rd_data(rd_data), .err(err_o));

// File: tb/sim_clock_calendar_unit.sv
module sim_clock_calendar_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic idx_wr = 1'b0;
  logic [7:0] idx_in = 8'h00;
  logic data_rd = 1'b0;
  logic data_wr = 1'b0;
  logic [7:0] rd0, rd1;
  logic err0, err1, pie0, pie1;

  int n_cmp = 0;
  int n_bad = 0;
  int pie0_cnt = 0;
  logic [7:0] r0, r1;
  logic e0, e1;

  always #2 clk = ~clk;

  // u0: leap-year February, 2 ticks per periodic pulse
  clock_calendar_unit #(.PI_DIV(2), .PI_PER_SEC(1024), .UIP_LEAD(8), .YEAR_BASE(1952),
    .INIT_SEC(59), .INIT_MIN(59), .INIT_HR(23), .INIT_WDAY(6),
    .INIT_MDAY(28), .INIT_MON(2), .INIT_YR(56)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .idx_wr(idx_wr), .idx_in(idx_in),
    .data_rd(data_rd), .data_wr(data_wr), .rd_data(rd0), .err_o(err0), .pie_o(pie0));

  // u1: year-end rollover, 4 ticks per second
  clock_calendar_unit #(.PI_DIV(1), .PI_PER_SEC(4), .UIP_LEAD(1), .YEAR_BASE(1952),
    .INIT_SEC(59), .INIT_MIN(59), .INIT_HR(23), .INIT_WDAY(3),
    .INIT_MDAY(31), .INIT_MON(12), .INIT_YR(57)) u1 (
    .clk(clk), .rst(rst), .tick(tick), .idx_wr(idx_wr), .idx_in(idx_in),
    .data_rd(data_rd), .data_wr(data_wr), .rd_data(rd1), .err_o(err1), .pie_o(pie1));

  always @(negedge clk) if (!rst && pie0) pie0_cnt++;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] ix);
    @(negedge clk); idx_wr = 1'b1; idx_in = ix;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic rd_only();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    r0 = rd0; r1 = rd1; e0 = err0; e1 = err1;
  endtask

  task automatic rd(input logic [7:0] ix);
    set_idx(ix);
    rd_only();
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 rd_data", rd0, 0);
    check("R11 err", err0, 0);
    check("R11 pie", pie0, 0);
    rst = 1'b0;
    rd_only();
    check("R11 index0 gives init seconds", r0, 59);
  endtask

  task automatic t_init_values();
    rd(8'h02); check("R8 minutes", r0, 59);
    rd(8'h04); check("R8 hours", r0, 23);
    rd(8'h06); check("R8 weekday", r0, 6);
    rd(8'h07); check("R8 mday", r0, 28);
    rd(8'h08); check("R8 month", r0, 2);
    rd(8'h09); check("R8 year offset", r0, 56);
    check("R8 u1 year", r1, 57);
  endtask

  task automatic t_status();
    rd(8'h0A); check("R3 status A idle", r0, 8'h26);
    rd(8'h0B); check("R4 status B", r0, 8'h46);
    rd(8'h0C); check("R5 status C", r0, 8'h00);
    check("R12 no error on good read", e0, 0);
  endtask

  task automatic t_index_latch();
    set_idx(8'h04);
    rd_only(); check("R2 latched index read 1", r0, 23);
    rd_only(); check("R2 latched index read 2", r0, 23);
    rd(8'h07); check("R2 new index", r0, 28);
  endtask

  task automatic t_errors();
    rd(8'h0D);
    check("R6 reg D error", e0, 1);
    check("R6 data held", r0, 28);
    @(negedge clk); check("R6 error one cycle", err0, 0);
    rd(8'h01); check("R6 unknown index error", e0, 1);
    @(negedge clk); data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
    check("R7 write error", err0, 1);
    rd(8'h00); check("R7 seconds untouched", r0, 59);
    check("R7 no error after", e0, 0);
  endtask

  task automatic t_year_rollover();
    run_ticks(3);
    rd(8'h0A); check("R3 u1 update flag set", r1, 8'hA6);
    run_ticks(1);
    rd(8'h00); check("R9 u1 sec wrap", r1, 0);
    rd(8'h02); check("R9 u1 min wrap", r1, 0);
    rd(8'h04); check("R9 u1 hr wrap", r1, 0);
    rd(8'h06); check("R9 u1 weekday", r1, 4);
    rd(8'h07); check("R10 u1 mday", r1, 1);
    rd(8'h08); check("R10 u1 month", r1, 1);
    rd(8'h09); check("R10 u1 year", r1, 58);
    rd(8'h0A); check("R3 u1 flag clear", r1, 8'h26);
  endtask

  task automatic t_leap_day();
    run_ticks(2027);
    rd(8'h0A); check("R3 u0 before window", r0, 8'h26);
    rd(8'h00); check("R9 u0 not yet advanced", r0, 59);
    run_ticks(1);
    rd(8'h0A); check("R3 u0 in window", r0, 8'hA6);
    run_ticks(16);
    @(negedge clk);
    check("R1 pulse count per second", pie0_cnt, 1024);
    rd(8'h00); check("R9 u0 sec", r0, 0);
    rd(8'h02); check("R9 u0 min", r0, 0);
    rd(8'h04); check("R9 u0 hr", r0, 0);
    rd(8'h06); check("R9 u0 weekday wrap", r0, 0);
    rd(8'h07); check("R10 leap February 29", r0, 29);
    rd(8'h08); check("R10 month kept", r0, 2);
    rd(8'h09); check("R10 year kept", r0, 56);
  endtask

  initial begin
    t_reset();
    t_init_values();
    t_status();
    t_index_latch();
    t_errors();
    t_year_rollover();
    t_leap_day();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule